// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Router

The router gathers a bank of level-sensitive device interrupt lines into one shared raw request vector and steers that vector to four processors. Each processor owns a 64-bit mask. Its interrupt output is raised while any unmasked raw bit is set. One extra input, the cascaded legacy interrupt controller output, is merged into raw bit 55.

Software reaches the 64-bit registers through a 32-bit register port. The port uses one shared 32-bit holding latch. A write to the lower half only fills the latch. The matching upper-half write then commits both halves at once. A read of the lower half returns the low word and parks the high word in the latch, where the next upper-half read picks it up. Offsets outside the map read as all ones, change nothing, and raise a one-cycle error pulse.

Top module: `irq_mask_router`

## Requirements
- R1: Raw bit i takes the level of device line i at every clock edge, with no edge latching. Raw bit 55 is additionally set while `legacy_irq` is high (logical OR).
- R2: `cpu_irq[n]` is high exactly when (mask n AND raw vector) is nonzero. It follows the state registers, so it reacts one cycle after a line change or after a mask commit.
- R3: Reading a CPU's request offset returns mask n AND raw vector. Reading the raw offset returns the raw vector.
- R4: Upper-half writes to request or raw offsets change no state and raise no error. Lower-half writes to those offsets only load the latch.
- R5: A write with `reg_addr[2]`=0 loads only the holding latch. A write with `reg_addr[2]`=1 to a mask offset commits {`reg_wdata`, latch} as the 64-bit mask, with the upper word in bits 63:32. Before that commit, the mask and `cpu_irq` are unchanged.
- R6: A mapped read with `reg_addr[2]`=0 returns bits 31:0 of the register and stores bits 63:32 in the latch. A mapped read with `reg_addr[2]`=1 returns the latch. Reads and writes share the same latch.
- R7: The register base is `reg_addr` with bits 2:0 cleared. The map is:
  - mask for CPU 0/1/2/3 at 0x200/0x240/0x600/0x640
  - request for CPU 0/1/2/3 at 0x280/0x2C0/0x680/0x6C0
  - raw vector at 0x300
- R8: An access to any other base has these effects:
  - a read returns 0xFFFFFFFF
  - a write changes no state, including the latch
  - `reg_err` is high for the cycle after the access
- R9: After reset, all masks, the raw vector, the latch, `reg_rdata` and `reg_err` are zero, and every `cpu_irq` is low.
- R10: `reg_rdata` is updated on the clock edge that samples `reg_rd` and holds its value in cycles without a read. When `reg_wr` and `reg_rd` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | LINES (64) | Level-sensitive device interrupt lines |
| legacy_irq | input | 1 | Cascaded legacy controller request, merged into raw bit 55 |
| reg_addr | input | ADDR_W (12) | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, valid the cycle after `reg_rd` |
| reg_err | output | 1 | One-cycle pulse after an unmapped access |
| cpu_irq | output | 4 | Interrupt output per CPU |

## Verification
The bench builds the block with its default parameters:
- 64 device lines, so raw and register width coincide and every bit, including the top word, can be read back;
- a 32-bit data path, which forces every register through the two-half latch protocol;
- four CPUs, which covers every mapped offset.

Line and mask patterns are drawn sparse, so that the per-CPU AND is sometimes empty and sometimes not. The legacy bit is exercised both alone and on top of device line 55.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_RAW  = 2'd3
  } reg_sel_e;

  // Offset distance from a CPU's mask register to its request register.
  localparam int unsigned REQ_DELTA = 32'h080;
  localparam int unsigned RAW_OFS   = 32'h300;

  // Mask offsets: CPU bit 0 adds 0x40, CPU bit 1 adds 0x400 on top of 0x200.
  function automatic int unsigned mask_ofs(input int unsigned cpu);
    int unsigned ofs;
    ofs = 32'h200;
    if (cpu[0]) ofs = ofs + 32'h040;
    if (cpu[1]) ofs = ofs + 32'h400;
    return ofs;
  endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int LINES      = 64,
  parameter int REG_W      = 64,
  parameter int LEGACY_BIT = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic             legacy_i,
  output logic [REG_W-1:0] raw_o
);

  logic [REG_W-1:0] raw_d;
  logic [REG_W-1:0] raw_q;

  always_comb begin
    raw_d             = REG_W'(lines_i);
    raw_d[LEGACY_BIT] = raw_d[LEGACY_BIT] | legacy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  // R1: the legacy request shows up in its raw bit one edge later
  p_legacy_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_i |=> raw_o[LEGACY_BIT]);

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_router_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [CPU_W-1:0]  cpu_o,
  output logic              upper_o
);

  logic [ADDR_W-1:0] base;

  assign base    = {addr_i[ADDR_W-1:3], 3'b000};
  assign upper_o = addr_i[2];

  always_comb begin
    sel_o = SEL_NONE;
    cpu_o = '0;
    if (base == ADDR_W'(RAW_OFS)) sel_o = SEL_RAW;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (base == ADDR_W'(mask_ofs(c))) begin
        sel_o = SEL_MASK;
        cpu_o = CPU_W'(c);
      end
      if (base == ADDR_W'(mask_ofs(c) + REQ_DELTA)) begin
        sel_o = SEL_REQ;
        cpu_o = CPU_W'(c);
      end
    end
  end

endmodule

// File: rtl/irq_mask_slice.sv
module irq_mask_slice #(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [REG_W-1:0] commit_val,
  input  logic [REG_W-1:0] raw_i,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] req_o,
  output logic             irq_o
);

  logic [REG_W-1:0] mask_d;
  logic [REG_W-1:0] mask_q;

  always_comb begin
    mask_d = mask_q;
    if (commit_en) mask_d = commit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign req_o  = mask_q & raw_i;
  assign irq_o  = |req_o;

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int LINES      = 64,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int NUM_CPU    = 4,
  parameter int LEGACY_BIT = 55
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   dev_irq,
  input  logic               legacy_irq,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  output logic [NUM_CPU-1:0] cpu_irq
);

  localparam int REG_W = 2 * DATA_W;
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Raw vector
  logic [REG_W-1:0] raw_q;

  irq_raw_capture #(
    .LINES(LINES), .REG_W(REG_W), .LEGACY_BIT(LEGACY_BIT)
  ) u_raw (
    .clk(clk), .rst_n(rst_int_n), .lines_i(dev_irq),
    .legacy_i(legacy_irq), .raw_o(raw_q)
  );

  // Address decode
  reg_sel_e         sel;
  logic [CPU_W-1:0] sel_cpu;
  logic             upper;

  irq_addr_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_dec (
    .addr_i(reg_addr), .sel_o(sel), .cpu_o(sel_cpu), .upper_o(upper)
  );

  // Per-CPU masks
  logic [DATA_W-1:0]             latch_q, latch_d;
  logic [NUM_CPU-1:0]            commit;
  logic [NUM_CPU-1:0][REG_W-1:0] mask_v;
  logic [NUM_CPU-1:0][REG_W-1:0] req_v;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    irq_mask_slice #(.REG_W(REG_W)) u_slice (
      .clk(clk), .rst_n(rst_int_n), .commit_en(commit[g]),
      .commit_val({reg_wdata, latch_q}), .raw_i(raw_q),
      .mask_o(mask_v[g]), .req_o(req_v[g]), .irq_o(cpu_irq[g])
    );

    // R5: a mask moves only on an upper-half write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
      !(reg_wr && reg_addr[2]) |=> $stable(mask_v[g]));
  end

  // Register access
  logic [REG_W-1:0]  rd_val;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_val = mask_v[sel_cpu];
      SEL_REQ:  rd_val = req_v[sel_cpu];
      SEL_RAW:  rd_val = raw_q;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    latch_d = latch_q;
    rdata_d = rdata_q;
    err_d   = 1'b0;
    commit  = '0;
    if (reg_wr) begin
      if (sel == SEL_NONE)      err_d = 1'b1;
      else if (!upper)          latch_d = reg_wdata;
      else if (sel == SEL_MASK) commit[sel_cpu] = 1'b1;
    end else if (reg_rd) begin
      if (sel == SEL_NONE) begin
        err_d   = 1'b1;
        rdata_d = '1;
      end else if (upper) begin
        rdata_d = latch_q;
      end else begin
        rdata_d = rd_val[DATA_W-1:0];
        latch_d = rd_val[REG_W-1:DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      latch_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_err   = err_q;

  // R2: no CPU may be interrupted while the raw vector is empty
  p_irq_needs_raw_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|cpu_irq) |-> (|raw_q));

  // R8: an unmapped read returns all ones and flags an error
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rd && !reg_wr && sel == SEL_NONE) |=> (reg_err && reg_rdata == '1));

  // R6: the latch holds while the port is idle
  p_latch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!reg_wr && !reg_rd) |=> $stable(latch_q));

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/tb_irq_mask_router.sv
module tb_irq_mask_router;
  localparam int LINES = 64, DW = 32, AW = 12, NCPU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [LINES-1:0] lines;
  logic             legacy;
  logic [AW-1:0]    addr;
  logic             wr, rd;
  logic [DW-1:0]    wdata;
  logic [DW-1:0]    rdata;
  logic             err;
  logic [NCPU-1:0]  cpu_irq;

  irq_mask_router dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(lines), .legacy_irq(legacy),
    .reg_addr(addr), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
    .reg_rdata(rdata), .reg_err(err), .cpu_irq(cpu_irq)
  );

  logic [63:0] raw_m;
  logic [63:0] mask_m [NCPU];
  logic [31:0] latch_m;
  logic [31:0] last_rd;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Returns kind: 0 unmapped, 1 mask, 2 request, 3 raw (R7)
  function automatic int decode(input logic [11:0] a, output int cpu);
    cpu = 0;
    case (a & 12'hFF8)
      12'h200: begin cpu = 0; return 1; end
      12'h240: begin cpu = 1; return 1; end
      12'h600: begin cpu = 2; return 1; end
      12'h640: begin cpu = 3; return 1; end
      12'h280: begin cpu = 0; return 2; end
      12'h2C0: begin cpu = 1; return 2; end
      12'h680: begin cpu = 2; return 2; end
      12'h6C0: begin cpu = 3; return 2; end
      12'h300: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < NCPU; c++) r[c] = |(mask_m[c] & raw_m);
    return r;
  endfunction

  task automatic chk_irq(input string tag);
    chk(tag, 64'(cpu_irq), 64'(exp_irq()));
  endtask

  task automatic do_lines(input logic [63:0] v, input logic leg);
    @(negedge clk);
    lines  = v;
    legacy = leg;
    @(negedge clk);
    raw_m = v;
    if (leg) raw_m[55] = 1'b1;
    chk_irq("R1/R2 cpu_irq after line change");
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    int k, c;
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    k = decode(a, c);
    if (k == 0) begin
      chk({tag, " R8 write err"}, 64'(err), 64'd1);
    end else begin
      chk({tag, " write no err"}, 64'(err), 64'd0);
      if (!a[2]) latch_m = d;
      else if (k == 1) mask_m[c] = {d, latch_m};
    end
    chk_irq({tag, " R2 cpu_irq after write"});
  endtask

  task automatic do_rd(input logic [11:0] a, input string tag);
    int k, c;
    logic [63:0] v;
    logic [31:0] e;
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    k = decode(a, c);
    if (k == 0) begin
      e = 32'hFFFF_FFFF;
      chk({tag, " R8 read err"}, 64'(err), 64'd1);
    end else begin
      chk({tag, " read no err"}, 64'(err), 64'd0);
      if (a[2]) e = latch_m;
      else begin
        v = (k == 1) ? mask_m[c] : (k == 2) ? (mask_m[c] & raw_m) : raw_m;
        e = v[31:0];
        latch_m = v[63:32];
      end
    end
    chk({tag, " rdata"}, 64'(rdata), 64'(e));
    last_rd = rdata;
  endtask

  function automatic logic [63:0] sparse64();
    return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
  endfunction

  function automatic logic [11:0] mask_addr(input int c);
    case (c)
      0: return 12'h200;
      1: return 12'h240;
      2: return 12'h600;
      default: return 12'h640;
    endcase
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [63:0] v;
    int c;
    void'($urandom(32'h5EED_1234));
    lines = '0; legacy = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    raw_m = '0; latch_m = '0; last_rd = '0;
    for (int i = 0; i < NCPU; i++) mask_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 cpu_irq at reset", 64'(cpu_irq), 64'd0);
    chk("R9 reg_err at reset", 64'(err), 64'd0);
    chk("R9 rdata at reset", 64'(rdata), 64'd0);
    do_rd(12'h300, "R9 raw low");
    do_rd(12'h640, "R9 mask3 low");

    // R5 low-half write only loads the latch
    do_lines(64'h8, 1'b0);
    do_wr(12'h200, 32'h8, "R5 low only");
    chk("R5 no irq before commit", 64'(cpu_irq), 64'd0);
    do_wr(12'h204, 32'h0, "R5 commit");
    chk("R5 R2 cpu0 raised", 64'(cpu_irq), 64'h1);

    // R3 request readback, R6 upper half from latch
    do_rd(12'h280, "R3 req0 low");
    do_rd(12'h284, "R6 req0 high");
    do_lines(64'h0, 1'b0);
    chk("R2 cpu0 drops with line", 64'(cpu_irq), 64'h0);

    // R1 legacy into bit 55
    do_wr(12'h600, 32'h0, "R1 mask2 low");
    do_wr(12'h604, 32'h0080_0000, "R1 mask2 high");
    do_lines(64'h0, 1'b1);
    chk("R1 legacy raises cpu2", 64'(cpu_irq), 64'h4);
    do_rd(12'h300, "R1 raw low");
    do_rd(12'h304, "R1 raw high");
    chk("R1 raw bit 55 read", 64'(last_rd), 64'h0080_0000);
    do_lines(64'h0080_0000_0000_0000, 1'b1);
    do_lines(64'h0080_0000_0000_0000, 1'b0);
    chk("R1 device line 55 alone", 64'(cpu_irq), 64'h4);

    // R4 writes to read-only offsets
    do_wr(12'h680, 32'h0, "R4 req2 low");
    do_wr(12'h684, 32'h0, "R4 req2 high");
    do_wr(12'h300, 32'h0, "R4 raw low");
    do_wr(12'h304, 32'h0, "R4 raw high");
    chk("R4 cpu2 still raised", 64'(cpu_irq), 64'h4);
    do_rd(12'h300, "R4 raw low");
    do_rd(12'h304, "R4 raw high");

    // R8 unmapped accesses
    do_rd(12'h000, "R8 unmapped read");
    do_wr(12'h100, 32'hDEAD_BEEF, "R8 unmapped low write");
    do_wr(12'h104, 32'hFFFF_FFFF, "R8 unmapped high write");
    do_rd(12'h604, "R8 latch untouched");
    do_rd(12'h600, "R8 mask2 low intact");

    // R7 every mask offset
    for (int i = 0; i < NCPU; i++) begin
      do_wr(mask_addr(i), 32'h1111_0000 * (i + 1), "R7 mask low");
      do_wr(mask_addr(i) | 12'h4, 32'h0000_2222 * (i + 1), "R7 mask high");
    end
    for (int i = 0; i < NCPU; i++) begin
      do_rd(mask_addr(i), "R7 mask readback low");
      do_rd(mask_addr(i) | 12'h4, "R7 mask readback high");
    end

    // R10 rdata holds without reads
    repeat (3) @(negedge clk);
    chk("R10 rdata held", 64'(rdata), 64'(last_rd));
    chk("R10 err idle", 64'(err), 64'd0);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 4)
        0: do_lines(sparse64(), ($urandom % 4) == 0);
        1: begin
          c = $urandom % NCPU;
          v = sparse64();
          do_wr(mask_addr(c), v[31:0], "R5 rnd mask low");
          do_wr(mask_addr(c) | 12'h4, v[63:32], "R5 rnd mask high");
        end
        2: begin
          case ($urandom % 3)
            0: addr = mask_addr($urandom % NCPU);
            1: addr = mask_addr($urandom % NCPU) + 12'h080;
            default: addr = 12'h300;
          endcase
          do_rd(addr, "R3 R6 rnd low");
          do_rd(addr | 12'h4, "R3 R6 rnd high");
        end
        default: begin
          if ($urandom % 2) do_rd(12'($urandom) & 12'hFFC, "R8 rnd any read");
          else do_wr(12'($urandom) & 12'hFFC, $urandom, "R8 rnd any write");
        end
      endcase
    end

    done = 1;
    report();
  end

endmodule